// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from four hardware sources and turns the most urgent qualifying one into a 3-bit priority level for the processor. The sources are two active-low external lines, a vertical-blank strobe and a display-coprocessor strobe. Each source sets a fixed bit of a 16-bit request register. A 16-bit enable register with the same bit layout holds one enable per source plus a global master enable.

Software reaches both registers through one write port and one read port. Bit 15 of a written word chooses whether the other 1 bits set or clear their register bits. Written 0 bits leave their register bits alone. The level output combines the pending requests, the per-source enables and the master enable in every cycle. Acknowledge handling, beam counting and coprocessor sequencing sit outside the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both registers read 0x0000 and the level output is 0.
- R2: A write with bit 15 = 1 sets every implemented register bit whose data bit is 1. A write with bit 15 = 0 clears those bits. Bits written as 0 keep their value. `wr_sel` = 0 selects the request register and `wr_sel` = 1 selects the enable register.
- R3: `rd_data` returns the register chosen by `rd_sel` (0 = request, 1 = enable) in the same cycle. Bit 15 and all unimplemented bits read 0. The request register implements bits 13, 5, 4 and 3. The enable register implements bits 14, 13, 5, 4 and 3.
- R4: `ext6_n` passes through a two-flop synchronizer. Once it has been low at three successive rising edges, request bit 13 is 1, and the bit is set again on every edge for as long as the synchronized line stays low. A clear written in that time does not take effect.
- R5: `ext2_n` behaves in the same way for request bit 3.
- R6: A rising edge of `vblank_stb` sets request bit 5 at that clock edge. The bit then holds until software clears it. Keeping the strobe high does not set the bit again.
- R7: A rising edge of `coproc_stb` sets request bit 4 at that clock edge. The bit then holds until software clears it.
- R8: Bit 13 maps to level 6, bits 5 and 4 map to level 3, and bit 3 maps to level 2. The output is the highest level among the qualifying requests, and 0 when there is none.
- R9: When enable bit 14 is 0, the level output is 0 whatever the other bits hold. Bit 14 never becomes a request: writing it to the request register leaves bit 14 reading 0.
- R10: A pending request whose own enable bit is 0 does not contribute to the level output.
- R11: If a hardware source sets a request bit in the same cycle as a software write that clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext6_n | input | 1 | Active-low external request line, level 6 |
| ext2_n | input | 1 | Active-low external request line, level 2 |
| vblank_stb | input | 1 | Start-of-vertical-blank strobe |
| coproc_stb | input | 1 | Display-coprocessor interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 request, 1 enable |
| wr_data | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| rd_sel | input | 1 | Read source: 0 request, 1 enable |
| rd_data | output | 16 | Selected register contents, bit 15 forced 0 |
| ipl | output | 3 | Encoded priority level, 0 for none |

## Verification
The embedded assertions check, on every cycle, the properties that are local in time. They confirm that the master enable forces a zero level, that a strobe edge leaves its request bit set, that a synchronized low line keeps bit 13 set, that an uncontested clear removes the vertical-blank request, and that an enabled bit 13 yields level 6. Some behaviours show only across the bench's scenarios. These are the three-edge latency through the synchronizer, the rule that a held strobe does not set its bit again, the masking of unimplemented bits, and the ranking when several sources are pending at once. A behavioural model compared against the design on every clock covers all of these.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext6_n,
  input  logic        ext2_n,
  input  logic        vblank_stb,
  input  logic        coproc_stb,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  output logic [2:0]  ipl
);

  localparam int BIT_SETCLR = 15;
  localparam int BIT_MASTER = 14;
  localparam int BIT_EXT6   = 13;
  localparam int BIT_VBL    = 5;
  localparam int BIT_COP    = 4;
  localparam int BIT_EXT2   = 3;
  localparam logic [15:0] REQ_MASK = (16'h1 << BIT_EXT6) | (16'h1 << BIT_VBL) |
                                     (16'h1 << BIT_COP)  | (16'h1 << BIT_EXT2);
  localparam logic [15:0] EN_MASK  = REQ_MASK | (16'h1 << BIT_MASTER);

  logic [15:0] req_q, en_q, hw_set, req_d, en_d, active;
  logic [1:0]  sync6, sync2;
  logic        vbl_prev, cop_prev, vbl_rise, cop_rise;

  function automatic logic [15:0] apply_wr(input logic [15:0] cur,
                                           input logic [15:0] d,
                                           input logic [15:0] mask);
    if (d[BIT_SETCLR]) return cur | (d & mask);
    else               return cur & ~(d & mask);
  endfunction

  assign vbl_rise = vblank_stb & ~vbl_prev;
  assign cop_rise = coproc_stb & ~cop_prev;

  always_comb begin
    hw_set           = '0;
    hw_set[BIT_EXT6] = ~sync6[1];
    hw_set[BIT_EXT2] = ~sync2[1];
    hw_set[BIT_VBL]  = vbl_rise;
    hw_set[BIT_COP]  = cop_rise;
  end

  assign req_d = ((wr_en && !wr_sel) ? apply_wr(req_q, wr_data, REQ_MASK) : req_q) | hw_set;
  assign en_d  = (wr_en && wr_sel) ? apply_wr(en_q, wr_data, EN_MASK) : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync6    <= 2'b11;
      sync2    <= 2'b11;
      vbl_prev <= 1'b0;
      cop_prev <= 1'b0;
      req_q    <= '0;
      en_q     <= '0;
    end else begin
      sync6    <= {sync6[0], ext6_n};
      sync2    <= {sync2[0], ext2_n};
      vbl_prev <= vblank_stb;
      cop_prev <= coproc_stb;
      req_q    <= req_d;
      en_q     <= en_d;
    end
  end

  assign active = req_q & en_q & {16{en_q[BIT_MASTER]}};

  always_comb begin
    if (active[BIT_EXT6])                      ipl = 3'd6;
    else if (active[BIT_VBL] || active[BIT_COP]) ipl = 3'd3;
    else if (active[BIT_EXT2])                 ipl = 3'd2;
    else                                       ipl = 3'd0;
  end

  assign rd_data = (rd_sel ? en_q : req_q) & {1'b0, 15'h7FFF};

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[BIT_MASTER] |-> ipl == 3'd0);

  // R6
  vbl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank_stb) |=> req_q[BIT_VBL]);

  // R7
  cop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coproc_stb) |=> req_q[BIT_COP]);

  // R4
  ext6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync6[1] |=> req_q[BIT_EXT6]);

  // R2
  vbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[BIT_SETCLR] && wr_data[BIT_VBL] &&
     !(vblank_stb && !vbl_prev)) |=> !req_q[BIT_VBL]);

  // R8
  level_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[BIT_MASTER] && en_q[BIT_EXT6] && req_q[BIT_EXT6]) |-> ipl == 3'd6);

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext6_n = 1'b1, ext2_n = 1'b1, vblank_stb = 1'b0, coproc_stb = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  ipl;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  irq_prio_ctrl uut (.clk(clk), .rst_n(rst_n), .ext6_n(ext6_n), .ext2_n(ext2_n),
    .vblank_stb(vblank_stb), .coproc_stb(coproc_stb), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ipl(ipl));

  always #5 clk = ~clk;

  // behavioural reference
  int m_req = 0, m_en = 0;
  int h6[2] = '{1, 1};
  int h2[2] = '{1, 1};
  int m_vb = 0, m_cp = 0;

  function automatic int m_level(int r, int e);
    int a;
    if (((e >> 14) & 1) == 0) return 0;
    a = r & e;
    if (a & 'h2000) return 6;
    if (a & 'h0030) return 3;
    if (a & 'h0008) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_en = 0; h6 = '{1, 1}; h2 = '{1, 1}; m_vb = 0; m_cp = 0;
    end else begin
      int nr, ne, d;
      nr = m_req; ne = m_en; d = int'(wr_data);
      if (wr_en && !wr_sel) nr = d[15] ? (nr | (d & 'h2038)) : (nr & ~(d & 'h2038));
      if (wr_en && wr_sel)  ne = d[15] ? (ne | (d & 'h6038)) : (ne & ~(d & 'h6038));
      if (h6[1] == 0) nr = nr | 'h2000;
      if (h2[1] == 0) nr = nr | 'h0008;
      if (vblank_stb && m_vb == 0) nr = nr | 'h0020;
      if (coproc_stb && m_cp == 0) nr = nr | 'h0010;
      h6[1] = h6[0]; h6[0] = int'(ext6_n);
      h2[1] = h2[0]; h2[0] = int'(ext2_n);
      m_vb = int'(vblank_stb); m_cp = int'(coproc_stb);
      m_req = nr; m_en = ne;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check({cur_req, " model ipl"}, int'(ipl), m_level(m_req, m_en));
      check({cur_req, " model read"}, int'(rd_data), rd_sel ? m_en : m_req);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(string tag, logic sel, int exp);
    rd_sel = sel; #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic lvl(string tag, int exp);
    #1 check(tag, int'(ipl), exp);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R1";
    rd("R1 req after reset", 0, 'h0000);
    rd("R1 en after reset", 1, 'h0000);
    lvl("R1 ipl after reset", 0);

    cur_req = "R2";
    wr(1, 16'hE038);
    rd("R2 enable set", 1, 'h6038);
    wr(1, 16'hFFFF);
    rd("R3 unimplemented bits read 0", 1, 'h6038);
    wr(1, 16'h2000);
    rd("R2 enable bit13 cleared", 1, 'h4038);
    wr(1, 16'h0000);
    rd("R2 zero write unchanged", 1, 'h4038);
    wr(1, 16'hA000);
    rd("R2 enable bit13 set again", 1, 'h6038);

    cur_req = "R5";
    ext2_n = 1'b0; tick(4);
    rd("R5 ext2 request", 0, 'h0008);
    lvl("R8 level 2", 2);
    ext2_n = 1'b1; tick(3);
    wr(0, 16'h0008);
    rd("R2 request cleared", 0, 'h0000);
    lvl("R8 level 0 nothing pending", 0);
    wr(0, 16'h8008);
    rd("R2 software set request", 0, 'h0008);
    lvl("R8 software request level", 2);

    cur_req = "R4";
    ext6_n = 1'b0; tick(4);
    rd("R4 ext6 request", 0, 'h2008);
    lvl("R8 level 6 beats 2", 6);
    wr(0, 16'h2000);
    rd("R4 clear ignored while low", 0, 'h2008);
    ext6_n = 1'b1; tick(3);
    wr(0, 16'h2008);
    rd("R4 cleared after release", 0, 'h0000);

    cur_req = "R6";
    vblank_stb = 1'b1; tick(1);
    rd("R6 vblank request", 0, 'h0020);
    lvl("R8 vblank level 3", 3);
    wr(0, 16'h0020);
    tick(2);
    rd("R6 held strobe no reset", 0, 'h0000);
    vblank_stb = 1'b0;
    cur_req = "R7";
    coproc_stb = 1'b1; tick(1);
    coproc_stb = 1'b0; tick(2);
    rd("R7 coproc request held", 0, 'h0010);
    lvl("R8 coproc level 3", 3);

    cur_req = "R9";
    ext6_n = 1'b0; tick(4);
    lvl("R8 level 6 over 3", 6);
    wr(1, 16'h4000);
    lvl("R9 master off", 0);
    rd("R9 enable bit14 cleared", 1, 'h2038);
    wr(0, 16'hC000);
    rd("R9 bit14 never a request", 0, 'h2010);
    wr(1, 16'hC000);
    lvl("R9 master back on", 6);
    ext6_n = 1'b1; tick(3);
    wr(0, 16'h2010);
    rd("R9 requests cleared", 0, 'h0000);

    cur_req = "R10";
    vblank_stb = 1'b1; tick(1);
    vblank_stb = 1'b0;
    wr(1, 16'h0030);
    rd("R10 enables trimmed", 1, 'h6008);
    lvl("R10 disabled source", 0);
    wr(1, 16'h8010);
    lvl("R10 other enable only", 0);
    wr(1, 16'h8020);
    lvl("R10 own enable on", 3);

    cur_req = "R11";
    wr_sel = 1'b0; wr_data = 16'h0020; wr_en = 1'b1; vblank_stb = 1'b1;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
    rd("R11 set wins over clear", 0, 'h0020);
    lvl("R11 level after race", 3);
    vblank_stb = 1'b0;
    tick(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule